// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block turns an asynchronous serial line into bytes. It waits for the line to fall, confirms the start bit half a bit later, and samples every following bit at its centre using a tick that runs at sixteen times the baud rate. After the data bits it samples an optional parity bit and the stop bit. The finished byte is then placed in a one-entry holding register and offered on a valid/ready output. A baud generator outside the block supplies the tick.

Three status flags sit beside the data: parity error, framing error and overrun. Each one rises in the same cycle that the byte becomes valid. Each one stays set through any number of later characters and through reads of the data. Only a pulse on the status-clear input brings them back to zero.

The output has back-pressure, but the line cannot stall. `out_valid` stays high and `out_data` stays stable until a cycle in which `out_ready` is also high. If another character finishes while the previous byte has not been taken, the new byte replaces it, `out_valid` remains high and the overrun flag is set. A byte taken in the same cycle that a new one completes does not count as an overrun.

Top module: `uart_rx_sticky`

## Requirements
- R1: A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit, and one stop bit. The byte on `out_data` equals the eight data bits, with the first data bit received in bit 0.
- R2: `par_mode` selects the parity mode, and the value in force when the start bit is confirmed applies to the whole frame. The encodings are: 0 = even (the parity bit is the XOR of the data), 1 = odd (the inverse of that XOR), 2 = space (the parity bit must be 0), 3 = mark (the parity bit must be 1), 4 to 7 = no parity bit in the frame and no parity check.
- R3: When the received parity bit differs from the expected value, `err_parity` rises in the same cycle that `out_valid` rises.
- R4: When the stop bit is sampled low, `err_frame` rises in the same cycle that `out_valid` rises.
- R5: Once set, an error flag stays set through later good characters and through data reads. It clears only in the cycle after `clr_status` is high.
- R6: A character that completes while `out_valid` is high and `out_ready` is low overwrites `out_data`, keeps `out_valid` high and sets the sticky `err_overrun` flag.
- R7: `out_valid` falls in the cycle after a cycle with both `out_valid` and `out_ready` high, unless a new character completes in that same cycle. While `out_valid` is high and `out_ready` is low, `out_data` does not change unless a new character completes.
- R8: A low pulse on the line shorter than half a bit returns the receiver to idle and produces no byte. A later frame is still received correctly.
- R9: After reset, `out_valid` is low, `out_data` is zero and all three error flags are low.
- R10: In no-parity mode (R2), the stop bit directly follows the eighth data bit, and `err_parity` is never set by that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input; idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the baud rate |
| par_mode | input | 3 | Parity mode select (see R2) |
| out_ready | input | 1 | Consumer accepts the held byte |
| clr_status | input | 1 | Clears all sticky error flags |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Held byte is waiting to be taken |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |

## Verification
The byte, `out_valid` and any error flags it raises all change in the same cycle. That cycle is the one after the tick that samples the middle of the stop bit. The monitor therefore waits for the rising edge of `out_valid` and checks the data and all three flags at the falling clock edge that follows. It then drives `out_ready` for a single cycle and expects `out_valid` low at the next falling edge, one cycle later. A status clear and its effect are likewise checked one cycle apart. In the overrun and glitch cases the monitor is turned off, and the ports are checked directly once the second frame, or the settling time, has passed.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    PM_EVEN  = 3'd0,
    PM_ODD   = 3'd1,
    PM_SPACE = 3'd2,
    PM_MARK  = 3'd3,
    PM_NONE  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // Any code above the last defined mode means "no parity".
  function automatic par_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd0:    decode_mode = PM_EVEN;
      3'd1:    decode_mode = PM_ODD;
      3'd2:    decode_mode = PM_SPACE;
      3'd3:    decode_mode = PM_MARK;
      default: decode_mode = PM_NONE;
    endcase
  endfunction

  // Parity bit value the sender should have produced for a data word.
  function automatic logic want_parity(input par_mode_e m, input logic [7:0] d);
    case (m)
      PM_EVEN: want_parity = ^d;
      PM_ODD:  want_parity = ~^d;
      PM_MARK: want_parity = 1'b1;
      default: want_parity = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  logic [STAGES-1:0] pipe_q;

  // Reset to the idle (high) level so no false start is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], line_in};
  end

  assign line_out = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              tick,
  input  logic [2:0]        mode_code,
  output logic              frm_done,
  output logic [DATA_W-1:0] frm_byte,
  output logic              frm_perr,
  output logic              frm_ferr
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  par_mode_e         mode_q;
  logic              perr_q;
  logic              done_q;
  logic [DATA_W-1:0] byte_q;
  logic              ferr_q;
  logic              bit_end;

  assign bit_end = (cnt_q == FULL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      mode_q  <= PM_NONE;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
      byte_q  <= '0;
      ferr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (state_q)
          RX_IDLE: begin
            if (!line_s) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            // Line back high before the start-bit centre means a glitch.
            if (line_s) begin
              state_q <= RX_IDLE;
            end else if (cnt_q == HALF_LAST) begin
              state_q <= RX_DATA;
              cnt_q   <= '0;
              idx_q   <= '0;
              perr_q  <= 1'b0;
              mode_q  <= decode_mode(mode_code);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (bit_end) begin
              cnt_q   <= '0;
              shift_q <= {line_s, shift_q[DATA_W-1:1]};
              if (idx_q == IDX_LAST) begin
                state_q <= (mode_q == PM_NONE) ? RX_STOP : RX_PAR;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (bit_end) begin
              cnt_q   <= '0;
              perr_q  <= (line_s != want_parity(mode_q, shift_q));
              state_q <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (bit_end) begin
              cnt_q   <= '0;
              done_q  <= 1'b1;
              byte_q  <= shift_q;
              ferr_q  <= !line_s;
              state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign frm_done = done_q;
  assign frm_byte = byte_q;
  assign frm_perr = perr_q;
  assign frm_ferr = ferr_q;
endmodule

// File: rtl/rx_hold_status.sv
module rx_hold_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_byte,
  input  logic              frm_perr,
  input  logic              frm_ferr,
  input  logic              out_ready,
  input  logic              clr_status,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic taken;
  logic lost;

  assign taken = out_valid && out_ready;
  assign lost  = frm_done && out_valid && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (frm_done) begin
      out_data  <= frm_byte;
      out_valid <= 1'b1;
    end else if (taken) begin
      out_valid <= 1'b0;
    end
  end

  // Sticky flags: a new event outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (frm_done && frm_perr) err_parity <= 1'b1;
      else if (clr_status)      err_parity <= 1'b0;
      if (frm_done && frm_ferr) err_frame <= 1'b1;
      else if (clr_status)      err_frame <= 1'b0;
      if (lost)                 err_overrun <= 1'b1;
      else if (clr_status)      err_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic [2:0]        par_mode,
  input  logic              out_ready,
  input  logic              clr_status,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic              line_s;
  logic              frm_done;
  logic [DATA_W-1:0] frm_byte;
  logic              frm_perr;
  logic              frm_ferr;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (rx_line),
    .line_out (line_s)
  );

  rx_frame_engine #(.DATA_W(DATA_W), .OSR(OSR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_s    (line_s),
    .tick      (os_tick),
    .mode_code (par_mode),
    .frm_done  (frm_done),
    .frm_byte  (frm_byte),
    .frm_perr  (frm_perr),
    .frm_ferr  (frm_ferr)
  );

  rx_hold_status #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_done    (frm_done),
    .frm_byte    (frm_byte),
    .frm_perr    (frm_perr),
    .frm_ferr    (frm_ferr),
    .out_ready   (out_ready),
    .clr_status  (clr_status),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun)
  );
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_done,
  input logic              out_ready,
  input logic              clr_status,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_overrun
);
  // R3
  perr_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> ($past(frm_done) && out_valid));

  // R4
  ferr_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> ($past(frm_done) && out_valid));

  // R5
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !clr_status) |=> err_parity);

  // R5
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !clr_status) |=> err_frame);

  // R5
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !frm_done) |=> (!err_parity && !err_frame && !err_overrun));

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && out_valid && !out_ready) |=> (err_overrun && out_valid));

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frm_done) |=> !out_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frm_done) |=> (out_valid && $stable(out_data)));
endmodule

bind uart_rx_sticky uart_rx_sticky_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_done    (frm_done),
  .out_ready   (out_ready),
  .clr_status  (clr_status),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .err_parity  (err_parity),
  .err_frame   (err_frame),
  .err_overrun (err_overrun)
);

// File: tb/tb_uart_rx_sticky.sv
module tb_uart_rx_sticky;
  localparam int OSR     = 16;
  localparam int TICK_DV = 2;
  localparam int BIT_CYC = OSR * TICK_DV;

  typedef struct {
    logic [7:0] d;
    bit         pe;
    bit         fe;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic [2:0] par_mode = 3'd0;
  logic       out_ready = 1'b0;
  logic       clr_status = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       err_parity;
  logic       err_frame;
  logic       err_overrun;

  int   n_total = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   mon_en = 1'b1;
  bit   m_pe = 1'b0;
  bit   m_fe = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;
  end

  uart_rx_sticky dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .par_mode(par_mode), .out_ready(out_ready), .clr_status(clr_status),
    .out_data(out_data), .out_valid(out_valid), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v, input int cycles);
    rx_line = v;
    repeat (cycles) @(negedge clk);
  endtask

  // Driver: pushes the expected item, then plays the frame on the line.
  task automatic send_frame(input logic [7:0] b, input logic [2:0] mode,
                            input bit bad_par, input bit stop_v,
                            input bit push, input string req);
    exp_t e;
    logic pb;
    bit   has_par;
    has_par = (mode < 3'd4);
    case (mode)
      3'd0:    pb = ^b;
      3'd1:    pb = ~^b;
      3'd2:    pb = 1'b0;
      default: pb = 1'b1;
    endcase
    pb = pb ^ bad_par;
    if (has_par && bad_par) m_pe = 1'b1;
    if (!stop_v) m_fe = 1'b1;
    e.d = b; e.pe = m_pe; e.fe = m_fe; e.req = req;
    if (push) sb_q.push_back(e);
    par_mode = mode;
    hold_bit(1'b0, BIT_CYC);
    for (int i = 0; i < 8; i++) hold_bit(b[i], BIT_CYC);
    if (has_par) hold_bit(pb, BIT_CYC);
    // A low stop bit is cut short so its tail is not taken for a new start.
    if (stop_v) hold_bit(1'b1, BIT_CYC);
    else        hold_bit(1'b0, BIT_CYC * 5 / 8);
    hold_bit(1'b1, 2 * BIT_CYC);
  endtask

  task automatic clear_flags(input string req);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    m_pe = 1'b0;
    m_fe = 1'b0;
    chk(!err_parity && !err_frame && !err_overrun, req, "flags after clear",
        {err_parity, err_frame, err_overrun}, 0);
  endtask

  // Monitor: takes each new byte, compares, then checks the hand-off.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && out_valid && rst_n) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected byte", out_data, 0);
        end else begin
          e = sb_q.pop_front();
          chk(out_data == e.d, e.req, "data", out_data, e.d);
          chk(err_parity == e.pe, e.req, "parity flag", err_parity, e.pe);
          chk(err_frame == e.fe, e.req, "frame flag", err_frame, e.fe);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid, "R7", "valid after take", out_valid, 0);
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(!out_valid && out_data == 8'h00, "R9", "valid/data after reset",
        {out_valid, out_data}, 0);
    chk(!err_parity && !err_frame && !err_overrun, "R9", "flags after reset",
        {err_parity, err_frame, err_overrun}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: clean frames in each parity mode
    send_frame(8'hA5, 3'd0, 1'b0, 1'b1, 1'b1, "R1");
    send_frame(8'h01, 3'd0, 1'b0, 1'b1, 1'b1, "R1");
    send_frame(8'h3C, 3'd1, 1'b0, 1'b1, 1'b1, "R2");
    send_frame(8'h7F, 3'd2, 1'b0, 1'b1, 1'b1, "R2");
    send_frame(8'h80, 3'd3, 1'b0, 1'b1, 1'b1, "R2");

    // R10: no parity bit in the frame
    send_frame(8'hC3, 3'd4, 1'b0, 1'b1, 1'b1, "R10");
    send_frame(8'h5A, 3'd7, 1'b0, 1'b1, 1'b1, "R10");

    // R3: parity error in odd mode, then R5: sticks through a good frame
    send_frame(8'h96, 3'd1, 1'b1, 1'b1, 1'b1, "R3");
    send_frame(8'h11, 3'd0, 1'b0, 1'b1, 1'b1, "R5");
    chk(err_parity, "R5", "parity flag after read", err_parity, 1);
    clear_flags("R5");

    // R3 in mark mode
    send_frame(8'h22, 3'd3, 1'b1, 1'b1, 1'b1, "R3");
    clear_flags("R5");

    // R4: framing error, sticky through a good frame
    send_frame(8'hE7, 3'd0, 1'b0, 1'b0, 1'b1, "R4");
    send_frame(8'h42, 3'd0, 1'b0, 1'b1, 1'b1, "R5");
    chk(err_frame, "R5", "frame flag after read", err_frame, 1);
    clear_flags("R5");

    // R6: two frames with nobody taking the first
    mon_en = 1'b0;
    send_frame(8'h12, 3'd0, 1'b0, 1'b1, 1'b0, "R6");
    chk(out_valid && out_data == 8'h12, "R7", "held byte", out_data, 8'h12);
    chk(!err_overrun, "R6", "no overrun yet", err_overrun, 0);
    send_frame(8'h34, 3'd0, 1'b0, 1'b1, 1'b0, "R6");
    chk(out_valid, "R6", "valid kept", out_valid, 1);
    chk(out_data == 8'h34, "R6", "overwritten byte", out_data, 8'h34);
    chk(err_overrun, "R6", "overrun flag", err_overrun, 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && err_overrun, "R5", "overrun kept after read",
        {out_valid, err_overrun}, 1);
    clear_flags("R5");

    // R8: short glitch on an idle line
    hold_bit(1'b0, 3 * TICK_DV);
    hold_bit(1'b1, 3 * BIT_CYC);
    chk(!out_valid, "R8", "no byte from glitch", out_valid, 0);
    mon_en = 1'b1;
    send_frame(8'h69, 3'd1, 1'b0, 1'b1, 1'b1, "R8");

    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0, "R1", "scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule